// File: doc/BRIEF.md
# Bus Hang Recovery Sequencer

This block frees a two-wire serial bus that a slave device holds low after losing clock count partway through a byte. Once started, it takes over the clock and data lines through open-drain drive enables and clocks the bus nine times. In each of those clocks it produces both a STOP and a START, so a slave stuck while sending and a slave stuck while receiving are both pushed back to idle. It then ends with a closing STOP. At the last edge it reads the line levels back and raises a flag if the bus is still held low.

Recovery begins in one of two ways. Host logic can pulse a request, or a built-in watchdog can start it after a pending transfer has run past its time limit while the controller status flags show a hung bus. Every step lasts a whole number of timing units. The unit is computed from the real bus rate, so a fast bus recovers in tens of microseconds and a slow bus gets the longer steps it needs. As the sequence starts, the block gives a one-clock pulse that clears the controller's lost-arbitration condition.

Top module: `bus_unjam`

## Requirements
- R1: Out of reset, neither line is driven low and `busy`, `done`, `stuck` and `arb_clr` are all low; while `busy` is low neither line is driven.
- R2: A `kick` pulse or a qualified watchdog expiry sampled while idle starts recovery: `busy` rises on the following cycle, and `arb_clr` is high for exactly that one cycle.
- R3: The sequence is nine clocks. Each clock has four one-unit phases, with `scl_oe`/`sda_oe` (1 = drive low) at 1/1, 0/1, 0/0, 0/1. On the bus this gives a SCL rising edge, a STOP (SDA rises while SCL is high) and a START (SDA falls while SCL is high) in every clock.
- R4: After the ninth clock a closing STOP takes three one-unit phases, at 1/1, 0/1, 0/0. Over the whole run the bus sees 9 STARTs, 10 STOPs and 10 SCL rising edges.
- R5: One unit is `u * TICKS_PER_US` system clocks, where `u = max(2, floor(1000000 / scl_hz) + 1)` and `scl_hz` is the real SCL rate in hertz, sampled at start. `busy` stays high for exactly 39 units, and changing `scl_hz` during a run has no effect on that run.
- R6: `done` is high for exactly one cycle per run, in the first cycle in which `busy` is low again.
- R7: At the final edge, `stuck` is set if SDA or SCL reads low, and cleared otherwise. It holds that value until the next start, which clears it.
- R8: A `kick` while `busy` is high is ignored: the run length is unchanged and no new `arb_clr` pulse appears.
- R9: The watchdog counts cycles while `xfer_pending` is high and the block is idle, and clears its count whenever either condition fails. It expires when the count reaches the limit, which is `tmo_ticks`, or `DEF_TMO_US * TICKS_PER_US` (one second by default) when `tmo_ticks` is 0. An expiry starts recovery only if `flag_bbusy` or `flag_nack` is high or `flag_cmpl` is low. Otherwise the count restarts and nothing else happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Explicit recovery request |
| xfer_pending | input | 1 | A bus transfer is outstanding |
| tmo_ticks | input | TMO_W | Watchdog limit in clocks; 0 selects the default |
| scl_hz | input | HZ_W | Real SCL rate in hertz |
| flag_cmpl | input | 1 | Controller reports transfer complete |
| flag_bbusy | input | 1 | Controller reports bus busy |
| flag_nack | input | 1 | Controller reports no acknowledge |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Drive SCL low when 1, release when 0 |
| sda_oe | output | 1 | Drive SDA low when 1, release when 0 |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| stuck | output | 1 | Bus still held low after recovery |
| arb_clr | output | 1 | One-cycle pulse clearing lost arbitration |

## Verification
The assertions check on every cycle that the lines are released while idle and that SDA is always driven low whenever SCL is. They also check that the line drives change only at unit boundaries, that each start has its clear pulse, that `done` is a lone pulse at the end of `busy`, that `stuck` reads low during a run, and that a run started without a request had a hung transfer pending behind it. The exact phase order, the count of STARTs and STOPs and the run length derived from the bus rate can only be shown by the bench's scenarios. The same holds for the flag seen when a slave holds SDA for good or lets go partway, and for the watchdog timing with a programmed limit and with the default limit.

// File: rtl/bunj_pkg.sv
package bunj_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLO,   // clock low, data low
    PH_CHI,   // clock released, data low
    PH_STP,   // both released: STOP edge
    PH_STA,   // clock high, data pulled: START edge
    PH_FLO,   // closing STOP: both low
    PH_FHI,   // closing STOP: clock released
    PH_FREL   // closing STOP: both released
  } phase_e;

  localparam int unsigned US_PER_S = 1_000_000;

  // Step length in microseconds from the real bus rate; a zero rate counts as 1 Hz.
  function automatic logic [31:0] unit_us_of(input logic [31:0] hz);
    logic [31:0] h;
    logic [31:0] q;
    h = (hz == 32'd0) ? 32'd1 : hz;
    q = US_PER_S / h + 32'd1;
    return (q < 32'd2) ? 32'd2 : q;
  endfunction

  function automatic logic [31:0] unit_ticks_of(input logic [31:0] us, input logic [31:0] tpu);
    return us * tpu;
  endfunction

  function automatic logic scl_low_in(input phase_e p);
    return (p == PH_CLO) || (p == PH_FLO);
  endfunction

  function automatic logic sda_low_in(input phase_e p);
    return (p == PH_CLO) || (p == PH_CHI) || (p == PH_STA) ||
           (p == PH_FLO) || (p == PH_FHI);
  endfunction

endpackage

// File: rtl/bunj_pacer.sv
module bunj_pacer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] len_in,
  output logic          unit_end
);
  logic [CW-1:0] len_q;
  logic [CW-1:0] cnt_q;

  assign unit_end = run && (cnt_q == len_q - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= CW'(2);
      cnt_q <= '0;
    end else if (load) begin
      len_q <= len_in;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= unit_end ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/bunj_wdog.sv
module bunj_wdog #(
  parameter int            TW      = 32,
  parameter logic [TW-1:0] DEF_LIM = {TW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pending,
  input  logic          hold,
  input  logic [TW-1:0] lim_in,
  input  logic          f_cmpl,
  input  logic          f_bbusy,
  input  logic          f_nack,
  output logic          fire
);
  logic [TW-1:0] wc_q;
  logic [TW-1:0] lim;
  logic          expire;
  logic          hung;

  assign lim    = (lim_in == '0) ? DEF_LIM : lim_in;
  assign expire = pending && !hold && (wc_q == lim - TW'(1));
  assign hung   = f_bbusy || f_nack || !f_cmpl;
  assign fire   = expire && hung;

  always_ff @(posedge clk) begin
    if (!rst_n)                        wc_q <= '0;
    else if (!pending || hold || expire) wc_q <= '0;
    else                               wc_q <= wc_q + TW'(1);
  end
endmodule

// File: rtl/bunj_phaser.sv
module bunj_phaser
  import bunj_pkg::*;
#(
  parameter int NCYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic unit_end,
  input  logic scl_sense,
  input  logic sda_sense,
  output logic busy,
  output logic done,
  output logic stuck,
  output logic arb_clr,
  output logic scl_low,
  output logic sda_low
);
  localparam int CYW = $clog2(NCYC + 1);

  phase_e         ph_q;
  logic [CYW-1:0] cyc_q;
  logic           last_cyc;

  assign last_cyc = (cyc_q == CYW'(NCYC - 1));
  assign busy     = (ph_q != PH_IDLE);
  assign scl_low  = scl_low_in(ph_q);
  assign sda_low  = sda_low_in(ph_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cyc_q   <= '0;
      done    <= 1'b0;
      stuck   <= 1'b0;
      arb_clr <= 1'b0;
    end else begin
      done    <= 1'b0;
      arb_clr <= 1'b0;
      if (go) begin
        ph_q    <= PH_CLO;
        cyc_q   <= '0;
        stuck   <= 1'b0;
        arb_clr <= 1'b1;
      end else if (unit_end) begin
        case (ph_q)
          PH_CLO:  ph_q <= PH_CHI;
          PH_CHI:  ph_q <= PH_STP;
          PH_STP:  ph_q <= PH_STA;
          PH_STA: begin
            if (last_cyc) ph_q <= PH_FLO;
            else begin
              ph_q  <= PH_CLO;
              cyc_q <= cyc_q + CYW'(1);
            end
          end
          PH_FLO:  ph_q <= PH_FHI;
          PH_FHI:  ph_q <= PH_FREL;
          PH_FREL: begin
            ph_q  <= PH_IDLE;
            done  <= 1'b1;
            stuck <= !sda_sense || !scl_sense;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_unjam.sv
module bus_unjam
  import bunj_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 125,
  parameter int unsigned DEF_TMO_US   = 1_000_000,
  parameter int          NCYC         = 9,
  parameter int          HZ_W         = 24,
  parameter int          TMO_W        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             xfer_pending,
  input  logic [TMO_W-1:0] tmo_ticks,
  input  logic [HZ_W-1:0]  scl_hz,
  input  logic             flag_cmpl,
  input  logic             flag_bbusy,
  input  logic             flag_nack,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             stuck,
  output logic             arb_clr
);
  localparam logic [TMO_W-1:0] DEF_LIM = TMO_W'(DEF_TMO_US * TICKS_PER_US);

  logic        wd_fire;
  logic        go;
  logic        unit_end;
  logic [31:0] unit_len;

  assign unit_len = unit_ticks_of(unit_us_of(32'(scl_hz)), 32'(TICKS_PER_US));
  assign go       = !busy && (kick || wd_fire);

  bunj_wdog #(.TW(TMO_W), .DEF_LIM(DEF_LIM)) u_wdog (
    .clk(clk), .rst_n(rst_n), .pending(xfer_pending), .hold(busy),
    .lim_in(tmo_ticks), .f_cmpl(flag_cmpl), .f_bbusy(flag_bbusy),
    .f_nack(flag_nack), .fire(wd_fire)
  );

  bunj_pacer #(.CW(32)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(go), .run(busy),
    .len_in(unit_len), .unit_end(unit_end)
  );

  bunj_phaser #(.NCYC(NCYC)) u_phaser (
    .clk(clk), .rst_n(rst_n), .go(go), .unit_end(unit_end),
    .scl_sense(scl_in), .sda_sense(sda_in), .busy(busy), .done(done),
    .stuck(stuck), .arb_clr(arb_clr), .scl_low(scl_oe), .sda_low(sda_oe)
  );
endmodule

// File: rtl/bunj_chk.sv
module bunj_chk (
  input logic clk,
  input logic rst_n,
  input logic kick,
  input logic xfer_pending,
  input logic flag_cmpl,
  input logic flag_bbusy,
  input logic flag_nack,
  input logic busy,
  input logic done,
  input logic stuck,
  input logic arb_clr,
  input logic scl_oe,
  input logic sda_oe,
  input logic unit_end
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_clr_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arb_clr |-> (busy && !$past(busy)));

  p_start_has_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> arb_clr);

  p_clock_low_data_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> sda_oe);

  p_unit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(unit_end)) |-> ($stable(scl_oe) && $stable(sda_oe)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_stuck_clear_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stuck);

  p_stuck_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && $past(!busy)) |-> $stable(stuck));

  p_kick_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kick) |=> !arb_clr);

  p_wd_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(kick)) |->
      ($past(xfer_pending) && $past(flag_bbusy || flag_nack || !flag_cmpl)));
endmodule

bind bus_unjam bunj_chk u_chk (
  .clk(clk), .rst_n(rst_n), .kick(kick), .xfer_pending(xfer_pending),
  .flag_cmpl(flag_cmpl), .flag_bbusy(flag_bbusy), .flag_nack(flag_nack),
  .busy(busy), .done(done), .stuck(stuck), .arb_clr(arb_clr),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .unit_end(unit_end)
);

// File: tb/sim_bus_unjam.sv
module sim_bus_unjam;
  localparam int TPU   = 2;
  localparam int DEFUS = 20;
  localparam int NC    = 9;
  localparam int LAST  = 4 * NC + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0;
  logic        pend = 1'b0;
  logic [31:0] tmo = 32'd0;
  logic [23:0] hz = 24'd375000;
  logic        fc = 1'b1;
  logic        fb = 1'b0;
  logic        fn = 1'b0;
  wire         scl_oe, sda_oe, busy, done, stuck, arb;

  integer hold_left = 0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || (hold_left > 0));

  always #4 clk = ~clk;

  bus_unjam #(.TICKS_PER_US(TPU), .DEF_TMO_US(DEFUS), .NCYC(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .kick(kick), .xfer_pending(pend),
    .tmo_ticks(tmo), .scl_hz(hz), .flag_cmpl(fc), .flag_bbusy(fb),
    .flag_nack(fn), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .stuck(stuck), .arb_clr(arb)
  );

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_ticks(input longint h);
    longint us;
    if (h == 0) us = 1000001;
    else begin
      us = 1000000 / h + 1;
      if (us < 2) us = 2;
    end
    return us * TPU;
  endfunction

  // Behavioural reference model, advanced on every rising edge.
  bit     m_busy = 0, m_done = 0, m_stuck = 0, m_arb = 0;
  longint m_step = 0, m_cnt = 0, m_len = 2, m_wc = 0;

  always @(posedge clk) begin
    longint lim;
    bit     fire;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_stuck = 0; m_arb = 0;
      m_step = 0; m_cnt = 0; m_len = 2; m_wc = 0;
    end else begin
      lim  = (tmo == 0) ? DEFUS * TPU : longint'(tmo);
      fire = pend && !m_busy && (m_wc == lim - 1) && (fb || fn || !fc);
      if (!pend || m_busy || m_wc == lim - 1) m_wc = 0;
      else m_wc = m_wc + 1;
      m_done = 0;
      m_arb  = 0;
      if (!m_busy && (kick || fire)) begin
        m_busy = 1; m_step = 0; m_cnt = 0; m_stuck = 0; m_arb = 1;
        m_len = exp_ticks(longint'(hz));
      end else if (m_busy) begin
        if (m_cnt == m_len - 1) begin
          m_cnt = 0;
          if (m_step == LAST) begin
            m_busy = 0; m_done = 1; m_stuck = !sda_line || !scl_line;
          end else m_step = m_step + 1;
        end else m_cnt = m_cnt + 1;
      end
    end
  end

  // Per-cycle comparison and bus event monitor, away from the active edge.
  int  n_start = 0, n_stop = 0, n_rise = 0, n_done = 0, n_arb = 0, n_busy = 0;
  bit  p_scl = 1, p_sda = 1;

  always @(negedge clk) begin
    bit es, ed;
    if (rst_n && !ended) begin
      es = m_busy && ((m_step < 4 * NC) ? (m_step % 4 == 0) : (m_step == 4 * NC));
      ed = m_busy && ((m_step < 4 * NC) ? (m_step % 4 != 2) : (m_step != LAST));
      check(scl_oe == es, (m_step >= 4 * NC) ? "R4" : "R3", "scl_oe", scl_oe, es);
      check(sda_oe == ed, (m_step >= 4 * NC) ? "R4" : "R3", "sda_oe", sda_oe, ed);
      check(busy == m_busy, "R5", "busy", busy, m_busy);
      check(done == m_done, "R6", "done", done, m_done);
      check(stuck == m_stuck, "R7", "stuck", stuck, m_stuck);
      check(arb == m_arb, "R2", "arb_clr", arb, m_arb);
      if (p_scl && scl_line && p_sda && !sda_line) n_start++;
      if (p_scl && scl_line && !p_sda && sda_line) n_stop++;
      if (!p_scl && scl_line) begin
        n_rise++;
        if (hold_left > 0) hold_left = hold_left - 1;
      end
      if (done) n_done++;
      if (arb)  n_arb++;
      if (busy) n_busy++;
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic clear_counts();
    n_start = 0; n_stop = 0; n_rise = 0; n_done = 0; n_arb = 0; n_busy = 0;
  endtask

  task automatic finish_run();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic kick_run(input longint rate);
    @(negedge clk);
    hz = 24'(rate);
    clear_counts();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    finish_run();
  endtask

  task automatic check_free_run(input longint rate, input string tag);
    check(n_busy == 39 * exp_ticks(rate), "R5", {tag, " run length"}, n_busy, 39 * exp_ticks(rate));
    check(n_start == 9, "R3", {tag, " START count"}, n_start, 9);
    check(n_stop == 10, "R4", {tag, " STOP count"}, n_stop, 10);
    check(n_rise == 10, "R4", {tag, " SCL rises"}, n_rise, 10);
    check(n_done == 1, "R6", {tag, " done pulses"}, n_done, 1);
    check(n_arb == 1, "R2", {tag, " arb_clr pulses"}, n_arb, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy && !done && !stuck && !arb, "R1", "reset outputs",
          {scl_oe, sda_oe, busy, done, stuck, arb}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !scl_oe && !sda_oe, "R1", "idle after reset", {busy, scl_oe, sda_oe}, 0);

    // R2 R3 R4 R5 R6: runs at several bus rates, including the 2-unit clamp
    kick_run(375000);
    check_free_run(375000, "375k");
    check(!stuck, "R7", "free bus flag", stuck, 0);
    kick_run(100000);
    check_free_run(100000, "100k");
    kick_run(2000000);
    check_free_run(2000000, "clamp");

    // R5 R8: rate change and extra kick during a run have no effect
    @(negedge clk);
    hz = 24'd375000;
    clear_counts();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    repeat (40) @(negedge clk);
    hz = 24'd100000;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    finish_run();
    check(n_busy == 39 * exp_ticks(375000), "R5", "latched rate", n_busy, 39 * exp_ticks(375000));
    check(n_arb == 1, "R8", "kick while busy", n_arb, 1);

    // R7: slave holds SDA for good, then a slave that lets go after 3 clocks
    hold_left = 1000000;
    kick_run(375000);
    check(stuck, "R7", "held bus flag", stuck, 1);
    hold_left = 0;
    repeat (10) @(negedge clk);
    check(stuck, "R7", "flag holds while idle", stuck, 1);
    @(negedge clk);
    hold_left = 3;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    check(!stuck && busy, "R7", "flag cleared at start", stuck, 0);
    finish_run();
    check(!stuck, "R7", "released bus flag", stuck, 0);

    // R9: clean flags never start recovery; a hung flag does after the limit
    @(negedge clk);
    clear_counts();
    tmo = 32'd30;
    pend = 1'b1;
    repeat (100) @(negedge clk);
    check(n_arb == 0 && !busy, "R9", "clean timeout starts nothing", n_arb, 0);
    pend = 1'b0;
    @(negedge clk);
    fn = 1'b1;
    pend = 1'b1;
    begin
      int waited = 0;
      for (int i = 1; i <= 200 && !busy; i++) begin
        @(negedge clk);
        waited = i;
      end
      check(waited == 30, "R9", "programmed limit", waited, 30);
    end
    pend = 1'b0;
    fn = 1'b0;
    finish_run();

    // R9: zero limit selects the default
    @(negedge clk);
    tmo = 32'd0;
    fb = 1'b1;
    pend = 1'b1;
    begin
      int waited = 0;
      for (int i = 1; i <= 400 && !busy; i++) begin
        @(negedge clk);
        waited = i;
      end
      check(waited == DEFUS * TPU, "R9", "default limit", waited, DEFUS * TPU);
    end
    pend = 1'b0;
    fb = 1'b0;
    finish_run();

    ended = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not end, actual 0 expected 1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule